// File: doc/BRIEF.md
# Pulse-Burst Frequency Multiplier

This block turns a slow train of input pulses into a train with two, four or eight times as many pulses. A free-running tick generator, divided down from the system clock by a programmable reload value, acts as the fast local pulse source. Each rising edge of the input clears a small burst counter and opens a gate. Gated ticks then go to the pulse output and to the counter. The gate closes when the counter bit picked by the multiplier select turns to one, so each burst has an exact length.

Everything runs on one system clock with a synchronous, active-low reset. The input may be asynchronous and is resynchronized first. The local pulse rate must be at least ten times the input pulse rate, so that each burst ends before the next input edge. If an edge comes early anyway, the burst restarts and a one-cycle overrun flag marks the event. The block has no data stream, so every port is a plain level or strobe with no valid/ready handshake and no back-pressure.

Top module: `pulse_burst_mult`

## Requirements
- R1: Reset is synchronous and active low. After a clock edge with `rst_n` low, `busy`, `pulse_out` and `overrun` are 0. After reset is released, no output pulse appears until a new rising edge of `pulse_in` is seen, and a reset in the middle of a burst cancels it.
- R2: The latency is fixed. If `pulse_in` is first sampled high at clock edge k, `busy` is still 0 after edge k+1 and is 1 after edge k+2. This holds for any input pulse width.
- R3: Each input rising edge produces exactly 2, 4 or 8 output pulses for `mult_sel` = 2'b00, 2'b01 or 2'b10, which stop on burst counter bit 1, 2 or 3. The unused code 2'b11 gives 2 pulses.
- R4: Each output pulse is high for exactly one clock cycle. Consecutive pulses in a burst are `div_reload`+1 cycles apart, so with `div_reload` = 0 they fill consecutive cycles.
- R5: `mult_sel` is captured when a burst starts. A change to it during a burst does not alter that burst's pulse count.
- R6: A rising edge of `pulse_in` while `busy` is high raises `overrun` for exactly one cycle and restarts the burst. Exactly the selected number of pulses follows the overrun cycle.
- R7: `busy` falls at the same clock edge that emits the final pulse of a burst, and no output pulse appears while `busy` was low in the previous cycle.
- R8: Only rising edges start bursts. Holding `pulse_in` high or letting it fall starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Raw, possibly asynchronous, slow input pulse train |
| mult_sel | input | 2 | Multiplier select: 00 x2, 01 x4, 10 x8, 11 x2 |
| div_reload | input | DIV_W | Tick divider reload value; tick period is value+1 cycles |
| pulse_out | output | 1 | Multiplied pulse train, one-cycle pulses |
| busy | output | 1 | High while a burst is in progress |
| overrun | output | 1 | One-cycle flag: an input edge arrived during a burst |

## Verification
The bench tests very short and very long input pulses. A level-triggered start would give extra bursts on a long pulse, and a slow synchronizer would miss a one-cycle pulse or shift the fixed latency. It also tests divider value 0, where a gate that checks the count one cycle late would let through an extra back-to-back pulse, and the unused select code, where a missing default would give a burst of the wrong length. Finally, it changes the select in the middle of a burst, sends an early input edge, and applies reset in the middle of a burst. An unlatched select would change the pulse count, a missing restart would leave a short burst with no overrun flag, and a reset that does not clear the gate would let pulses leak out afterwards.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [1:0] {
    MUL_X2   = 2'b00,
    MUL_X4   = 2'b01,
    MUL_X8   = 2'b10,
    MUL_SPARE = 2'b11
  } mul_sel_e;

  // counter bit that ends the burst for a given select; spare falls back to x2
  function automatic logic [CNT_W-1:0] stop_mask(input logic [1:0] sel);
    logic [CNT_W-1:0] m;
    case (sel)
      MUL_X4:  m = CNT_W'(4);
      MUL_X8:  m = CNT_W'(8);
      default: m = CNT_W'(2);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pbm_edge_sync.sv
module pbm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[MSB-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[MSB];
  end

  assign rise = sync_q[MSB] & ~prev_q;
endmodule

// File: rtl/pbm_tick_gen.sv
module pbm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= reload;
    else           cnt_q <= cnt_q - DIV_W'(1);
  end
endmodule

// File: rtl/pbm_burst_ctrl.sv
module pbm_burst_ctrl
  import pbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       pulse,
  output logic       busy,
  output logic       overrun
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, mask_q;
  logic             busy_q, pulse_q, ovr_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mask_q  <= CNT_W'(2);
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      ovr_q   <= 1'b0;
      if (start) begin
        cnt_q  <= '0;
        mask_q <= stop_mask(sel);
        busy_q <= 1'b1;
        ovr_q  <= busy_q;
      end else if (busy_q && tick) begin
        cnt_q   <= cnt_nxt;
        pulse_q <= 1'b1;
        if ((cnt_nxt & mask_q) != '0) busy_q <= 1'b0;
      end
    end
  end

  assign pulse   = pulse_q;
  assign busy    = busy_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/pulse_burst_mult.sv
module pulse_burst_mult #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [1:0]       mult_sel,
  input  logic [DIV_W-1:0] div_reload,
  output logic             pulse_out,
  output logic             busy,
  output logic             overrun
);
  logic start_w;
  logic tick_w;

  pbm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pulse_in),
    .rise (start_w)
  );

  pbm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .reload(div_reload),
    .tick  (tick_w)
  );

  pbm_burst_ctrl u_burst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start_w),
    .tick   (tick_w),
    .sel    (mult_sel),
    .pulse  (pulse_out),
    .busy   (busy),
    .overrun(overrun)
  );
endmodule

// File: rtl/pbm_checker.sv
module pbm_checker (
  input logic clk,
  input logic rst_n,
  input logic pulse_out,
  input logic busy,
  input logic overrun
);
  logic [4:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                seen_q <= '0;
    else if (!busy || overrun) seen_q <= '0;
    else if (pulse_out)        seen_q <= seen_q + 5'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !pulse_out && !overrun));

  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (seen_q == 5'd1 || seen_q == 5'd3 || seen_q == 5'd7));

  p_ovr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

  p_ovr_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> (busy && !pulse_out));

  p_last_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pulse_out);

  p_no_idle_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> $past(busy));
endmodule

bind pulse_burst_mult pbm_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pulse_out(pulse_out),
  .busy     (busy),
  .overrun  (overrun)
);

// File: tb/pulse_burst_mult_tb_top.sv
module pulse_burst_mult_tb_top;
  localparam int DIV_W = 8;
  localparam int NV    = 6;
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 2, 1};
  localparam int V_DIV [NV] = '{3, 2, 1, 4, 0, 5};
  localparam int V_WID [NV] = '{1, 4, 2, 3, 1, 60};
  localparam int V_EXP [NV] = '{2, 4, 8, 2, 8, 4};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pulse_in = 1'b0;
  logic [1:0]       mult_sel = 2'b00;
  logic [DIV_W-1:0] div_reload = '0;
  logic             pulse_out, busy, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pulse_burst_mult #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .mult_sel(mult_sel),
    .div_reload(div_reload), .pulse_out(pulse_out), .busy(busy), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    int pulses, ovr_cnt, after_ovr, gap_bad, last_hi, win;
    bit seen_ovr;
    // R1: reset state
    step(); step();
    check("R1 busy in reset", busy, 0);
    check("R1 pulse_out in reset", pulse_out, 0);
    check("R1 overrun in reset", overrun, 0);
    rst_n = 1'b1;
    repeat (20) step();
    check("R1 no pulse before edge", pulse_out, 0);

    // table of vectors: R2 latency, R3 count, R4 spacing, R8 width independence
    for (int v = 0; v < NV; v++) begin
      mult_sel   = 2'(V_SEL[v]);
      div_reload = DIV_W'(V_DIV[v]);
      pulses = 0; gap_bad = 0; last_hi = -1; ovr_cnt = 0;
      win = V_WID[v] + 14 + 9 * (V_DIV[v] + 1);
      pulse_in = 1'b1;
      for (int c = 0; c < win; c++) begin
        step();
        if (c + 1 == V_WID[v]) pulse_in = 1'b0;
        if (c == 1) check("R2 busy low after 2 edges", busy, 0);
        if (c == 2) check("R2 busy high after 3 edges", busy, 1);
        if (overrun) ovr_cnt++;
        if (pulse_out) begin
          if (last_hi >= 0 && c - last_hi != V_DIV[v] + 1) gap_bad++;
          last_hi = c;
          pulses++;
        end
      end
      check($sformatf("R3 R8 pulse count vec %0d", v), pulses, V_EXP[v]);
      check($sformatf("R4 pulse spacing vec %0d", v), gap_bad, 0);
      check($sformatf("R8 no overrun vec %0d", v), ovr_cnt, 0);
      check($sformatf("R7 idle at end vec %0d", v), busy, 0);
    end

    // R5: select changed mid-burst
    mult_sel = 2'b01; div_reload = DIV_W'(2); pulses = 0;
    pulse_in = 1'b1;
    for (int c = 0; c < 60; c++) begin
      step();
      if (c == 0) pulse_in = 1'b0;
      if (c == 5) mult_sel = 2'b10;
      if (pulse_out) pulses++;
    end
    check("R5 select held for burst", pulses, 4);

    // R6: early edge restarts the burst
    mult_sel = 2'b10; div_reload = DIV_W'(9);
    ovr_cnt = 0; after_ovr = 0; seen_ovr = 1'b0;
    pulse_in = 1'b1;
    for (int c = 0; c < 140; c++) begin
      step();
      if (c == 0 || c == 30) pulse_in = 1'b0;
      if (c == 29) pulse_in = 1'b1;
      if (seen_ovr && pulse_out) after_ovr++;
      if (overrun) begin
        ovr_cnt++;
        seen_ovr = 1'b1;
        check("R6 busy held at overrun", busy, 1);
      end
    end
    check("R6 overrun flagged once", ovr_cnt, 1);
    check("R6 full burst after restart", after_ovr, 8);
    check("R6 idle after restarted burst", busy, 0);

    // R1: reset in the middle of a burst
    mult_sel = 2'b10; div_reload = DIV_W'(3); pulses = 0;
    pulse_in = 1'b1;
    step();
    pulse_in = 1'b0;
    repeat (12) step();
    rst_n = 1'b0;
    step();
    check("R1 busy cleared by reset", busy, 0);
    check("R1 pulse_out cleared by reset", pulse_out, 0);
    step();
    rst_n = 1'b1;
    for (int c = 0; c < 50; c++) begin
      step();
      if (pulse_out) pulses++;
    end
    check("R1 no pulses after mid-burst reset", pulses, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule